// File: doc/BRIEF.md
# Split-Word Padded Serial Frame Transmitter

This block sends one 12-bit sample over an asynchronous serial line as a six-byte frame. A single-cycle strobe hands the sample over. The sample is then cut into a lower half and an upper half of six bits each. Each half is sent in its own byte, with a two-bit tag that names the half. A modulo-256 checksum of the two payload bytes closes the frame.

Every payload byte, and the checksum, follows an all-ones pad byte. A receiver that has lost its place reads the pad as an idle line. The next falling edge is then a true start bit, so the receiver locks on again.

The block holds the bit-period divider, the bit serializer and the byte sequencer. It reports a busy level and a one-cycle done pulse. With the default divider of 128 on a 100 MHz clock, a frame takes 76.8 us. This fits inside the sample interval of roughly 112 us.

Top module: `split_frame_tx`

## Requirements
- R1: A frame is six bytes in a fixed order: slot 0 pad, slot 1 low payload, slot 2 pad, slot 3 high payload, slot 4 pad, slot 5 checksum. Every pad byte is 0xFF.
- R2: The low payload byte is {2'b01, sample[5:0]}: tag 01 in bits [7:6], sample bits [5:0] in bits [5:0].
- R3: The high payload byte is {2'b10, sample[11:6]}: tag 10 in bits [7:6], sample bits [11:6] in bits [5:0].
- R4: The checksum byte is (low payload + high payload) mod 256.
- R5: Each byte goes out as a low start bit, then eight data bits least significant first, then a high stop bit. Bytes follow each other with no idle gap.
- R6: Every line bit lasts exactly CLK_DIV clock cycles. The first start bit begins in the cycle after the accepting clock edge. A frame lasts 60*CLK_DIV cycles (7680 with the default of 128).
- R7: `busy` is high from the cycle after acceptance for the whole frame, and low otherwise.
- R8: `done` is high for exactly one cycle: the first cycle after the frame in which `busy` is low.
- R9: A strobe that arrives while `busy` is high is ignored. The frame in flight is not restarted, and its payload still comes from the sample that was first accepted.
- R10: In reset and between frames, `txd` is high, `busy` is low and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; the sample is accepted when `busy` is low |
| smp_data | input | 12 | Sample value |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last stop bit |

## Verification
A wrong divider count shows at the port within the first bit period: the start bit ends too early or too late. From that point the line drifts against the reference model by a whole number of cycles. A wrong slot or bit index puts a byte in the wrong place, or a bit out of position. This shows within one byte time as a mismatched data bit or a missing stop bit. A sample register that reloads while busy changes the payload. This shows only when the high byte or the checksum goes out, up to five byte times later, so the bench places a stray strobe early in the frame.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int BYTE_W      = 8;
  localparam int HALF_W      = 6;
  localparam int TAG_W       = 2;
  localparam int SAMPLE_W    = 2 * HALF_W;
  localparam int LINE_BITS   = BYTE_W + 2;
  localparam int FRAME_BYTES = 6;
  localparam int IDX_W       = $clog2(LINE_BITS);

  localparam logic [TAG_W-1:0]  TAG_LOW  = 2'b01;
  localparam logic [TAG_W-1:0]  TAG_HIGH = 2'b10;
  localparam logic [BYTE_W-1:0] PAD_BYTE = 8'hFF;

  typedef logic [BYTE_W-1:0]   byte_t;
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [IDX_W-1:0]    bidx_t;

  typedef enum logic [2:0] {
    SL_PAD0 = 3'd0,
    SL_LOW  = 3'd1,
    SL_PAD1 = 3'd2,
    SL_HIGH = 3'd3,
    SL_PAD2 = 3'd4,
    SL_SUM  = 3'd5
  } slot_e;

  function automatic byte_t low_byte(sample_t s);
    return {TAG_LOW, s[HALF_W-1:0]};
  endfunction

  function automatic byte_t high_byte(sample_t s);
    return {TAG_HIGH, s[SAMPLE_W-1:HALF_W]};
  endfunction

  function automatic byte_t sum_byte(sample_t s);
    return low_byte(s) + high_byte(s);
  endfunction

  function automatic byte_t slot_byte(slot_e sl, sample_t s);
    case (sl)
      SL_LOW:  return low_byte(s);
      SL_HIGH: return high_byte(s);
      SL_SUM:  return sum_byte(s);
      default: return PAD_BYTE;
    endcase
  endfunction

  // bit 0 is the start bit, the last index the stop bit, data in between LSB first
  function automatic logic line_bit(byte_t b, bidx_t idx);
    if (idx == '0) return 1'b0;
    if (idx == bidx_t'(LINE_BITS - 1)) return 1'b1;
    return b[3'(idx - bidx_t'(1))];
  endfunction
endpackage

// File: rtl/sfx_baud.sv
module sfx_baud #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/sfx_serial.sv
module sfx_serial
  import sfx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  run,
  input  logic  tick,
  input  byte_t byte_in,
  output logic  txd,
  output logic  byte_end,
  output bidx_t bit_idx
);
  localparam bidx_t IDX_LAST = bidx_t'(LINE_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_idx <= '0;
    end else if (load) begin
      bit_idx <= '0;
    end else if (tick) begin
      bit_idx <= (bit_idx == IDX_LAST) ? '0 : bit_idx + 1'b1;
    end
  end

  assign byte_end = tick && (bit_idx == IDX_LAST);
  assign txd      = run ? line_bit(byte_in, bit_idx) : 1'b1;
endmodule

// File: rtl/sfx_seq.sv
module sfx_seq
  import sfx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe,
  input  sample_t sample_in,
  input  logic    byte_end,
  output logic    busy,
  output logic    done,
  output slot_e   slot,
  output sample_t sample_q,
  output logic    accept,
  output logic    frame_end,
  output byte_t   cur_byte
);
  assign accept    = strobe && !busy;
  assign frame_end = byte_end && (slot == SL_SUM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      slot     <= SL_PAD0;
      sample_q <= '0;
    end else begin
      done <= frame_end;
      if (accept) begin
        busy     <= 1'b1;
        slot     <= SL_PAD0;
        sample_q <= sample_in;
      end else if (frame_end) begin
        busy <= 1'b0;
        slot <= SL_PAD0;
      end else if (byte_end) begin
        slot <= slot_e'(slot + 3'd1);
      end
    end
  end

  assign cur_byte = slot_byte(slot, sample_q);
endmodule

// File: rtl/split_frame_tx.sv
module split_frame_tx
  import sfx_pkg::*;
#(
  parameter int CLK_DIV = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                txd,
  output logic                busy,
  output logic                done
);
  logic    bit_tick;
  logic    byte_end;
  logic    frame_end;
  logic    accept;
  slot_e   slot;
  sample_t sample_q;
  byte_t   cur_byte;
  bidx_t   bit_idx;

  sfx_baud #(.DIV(CLK_DIV)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (bit_tick)
  );

  sfx_serial u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .run     (busy),
    .tick    (bit_tick),
    .byte_in (cur_byte),
    .txd     (txd),
    .byte_end(byte_end),
    .bit_idx (bit_idx)
  );

  sfx_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (smp_valid),
    .sample_in(smp_data),
    .byte_end (byte_end),
    .busy     (busy),
    .done     (done),
    .slot     (slot),
    .sample_q (sample_q),
    .accept   (accept),
    .frame_end(frame_end),
    .cur_byte (cur_byte)
  );
endmodule

// File: rtl/sfx_chk.sv
module sfx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        txd,
  input logic        busy,
  input logic        done,
  input logic        bit_tick,
  input logic        byte_end,
  input logic [2:0]  slot,
  input logic [11:0] sample_q
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R10
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R5
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |-> txd); // R5
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(bit_tick)) |-> $stable(txd)); // R6
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sample_q)); // R9
  AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= 3'd5); // R1
endmodule

bind split_frame_tx sfx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .txd     (txd),
  .busy    (busy),
  .done    (done),
  .bit_tick(bit_tick),
  .byte_end(byte_end),
  .slot    (slot),
  .sample_q(sample_q)
);

// File: tb/split_frame_tx_bench.sv
module split_frame_tx_bench;
  localparam int DIV       = 128;
  localparam int NBITS     = 60;
  localparam int FRAME_CYC = NBITS * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        txd, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  split_frame_tx #(.CLK_DIV(DIV)) u_split_frame_tx (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .txd(txd), .busy(busy), .done(done)
  );

  // behavioural reference: a list of line bits and a position counter
  bit m_busy = 0;
  bit m_done = 0;
  int m_pos  = 0;
  bit m_bits[NBITS];

  function automatic int ref_low(int s);  return 64 + (s % 64);             endfunction
  function automatic int ref_high(int s); return 128 + (s / 64);            endfunction
  function automatic int ref_sum(int s);  return (ref_low(s) + ref_high(s)) % 256; endfunction

  task automatic build_bits(int s);
    int seq[6];
    seq[0] = 255; seq[1] = ref_low(s); seq[2] = 255;
    seq[3] = ref_high(s); seq[4] = 255; seq[5] = ref_sum(s);
    for (int k = 0; k < 6; k++) begin
      m_bits[10*k] = 0;
      for (int i = 0; i < 8; i++) m_bits[10*k+1+i] = ((seq[k] >> i) & 1) != 0;
      m_bits[10*k+9] = 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pos = 0;
    end else if (m_busy) begin
      m_done = 0;
      if (m_pos == FRAME_CYC - 1) begin
        m_busy = 0; m_done = 1;
      end else begin
        m_pos++;
      end
    end else begin
      m_done = 0;
      if (smp_valid) begin
        m_busy = 1; m_pos = 0; build_bits(int'(smp_data));
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !finished) begin
      check(txd == (m_busy ? m_bits[m_pos / DIV] : 1'b1), "R6 line bit", txd,
            m_busy ? m_bits[m_pos / DIV] : 1);
      check(busy == m_busy, "R7 busy", busy, m_busy);
      check(done == m_done, "R8 done", done, m_done);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic send(int s, bit stray, int other);
    bit cap[NBITS];
    int got;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 12'(s);
    @(negedge clk);
    smp_valid = 1'b0;
    for (int cyc = 1; cyc <= FRAME_CYC; cyc++) begin
      if (cyc % DIV == DIV / 2) cap[cyc / DIV] = txd;
      if (stray) begin
        smp_valid = (cyc == DIV * 3);
        smp_data  = 12'(other);
      end
      @(negedge clk);
    end
    smp_valid = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R8 done after last stop bit", {done, busy}, 2);
    check(txd == 1'b1, "R10 line idle after frame", txd, 1);
    for (int k = 0; k < 6; k++) begin
      got = 0;
      for (int i = 0; i < 8; i++) if (cap[10*k+1+i]) got |= (1 << i);
      check(cap[10*k] == 0, "R5 start bit", cap[10*k], 0);
      check(cap[10*k+9] == 1, "R5 stop bit", cap[10*k+9], 1);
      case (k)
        0, 2, 4: check(got == 255, "R1 pad byte", got, 255);
        1:       check(got == ref_low(s), "R2 low payload", got, ref_low(s));
        3:       check(got == ref_high(s), "R3 high payload", got, ref_high(s));
        default: check(got == ref_sum(s), "R4 checksum", got, ref_sum(s));
      endcase
      if (stray && k == 3)
        check(got == ref_high(s), "R9 stray strobe ignored", got, ref_high(s));
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 done single cycle", {done, busy}, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0 && done == 1'b0, "R10 reset state",
          {txd, busy, done}, 4);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (5) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R10 idle after reset", {txd, busy}, 2);
    send(12'h000, 0, 0);
    send(12'hFFF, 0, 0);
    send(12'hA5C, 0, 0);
    send(12'h03F, 0, 0);
    send(12'hFC0, 0, 0);
    send(12'h123, 1, 12'hEDC);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL R6 watchdog: actual still running expected frames complete");
      summary();
      $finish;
    end
  end
endmodule